// File: doc/BRIEF.md
# Nonoverlapping two-phase clock generator

This block derives the control phases for a double-sampled switched-capacitor track-and-hold and its comparator latches from one fast master clock. One sample period T spans `DIV` master cycles. Two complementary hold phases, `ph_one` and `ph_two`, each repeat every 2T and alternate, so the two interleaved channels use the same amplifier in turn. A full-rate phase `ph_full` repeats every T and controls the shared sampling switch, which gives both channels one common sampling instant.

Each hold phase has an early copy that rises with it and opens `EARLY` master cycles before it. The bottom-plate switches driven by the early copy therefore open first. The full-rate phase opens another `LEAD` cycles ahead of the early copy. Counters on the master clock set every dead time, which removes the need for analog delay chains. A registered interlock with cross-coupled feedback keeps a hold phase from rising while the other one is still high. A one-cycle latch strobe marks the last cycle of each `ph_two` pulse, when the hold output has settled.

Elaboration stops on parameter values that would leave any phase pulse with zero or negative width. The rule is: `DEAD >= 1`, `EARLY >= 1`, `LEAD >= 0`, and `DEAD + EARLY + LEAD < DIV`.

Top module: `nonoverlap_phase_gen`

## Requirements
Notation used below:
- k is the number of rising `clk` edges seen with `rst_n` high since reset was last released.
- For k >= 1, the frame position is p = (k-1) mod 2·DIV.
- The local position is lp = p in the first half of the frame (p < DIV) and lp = p - DIV in the second half.
- Outputs are sampled after the k-th edge.

- R1: While `rst_n` is low, and for k = 0 after release, every output is 0.
- R2: `ph_one` is 1 exactly when p < DIV and lp >= DEAD. It is a pulse of width DIV-DEAD that repeats every 2·DIV cycles.
- R3: `ph_two` is 1 exactly when p >= DIV and lp >= DEAD. It is a pulse of width DIV-DEAD.
- R4: `ph_one` and `ph_two` are never 1 in the same cycle. After either one falls, both stay 0 for DEAD cycles.
- R5: `ph_one_early` is 1 exactly when p < DIV and DEAD <= lp < DIV-EARLY. `ph_two_early` is 1 under the same rule for p >= DIV. Each early copy rises in the same cycle as its hold phase and falls EARLY cycles before it.
- R6: `ph_full` is 1 exactly when DEAD <= lp < DIV-EARLY-LEAD, in both halves. It therefore repeats every DIV cycles and falls LEAD cycles before the active early copy.
- R7: `latch_stb` is 1 exactly when p = 2·DIV-1. That is the last cycle in which `ph_two` is 1, and the strobe lasts one cycle.
- R8: After each reset release, the first hold phase to rise is `ph_one`, at k = DEAD+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, DIV cycles per sample period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_full | output | 1 | Full-rate phase for the shared sampling switch |
| ph_one | output | 1 | Hold phase of the first channel, period 2T |
| ph_two | output | 1 | Hold phase of the second channel, period 2T |
| ph_one_early | output | 1 | Early-opening copy of `ph_one` |
| ph_two_early | output | 1 | Early-opening copy of `ph_two` |
| latch_stb | output | 1 | One-cycle comparator latch strobe at the end of `ph_two` |

## Verification
The assertions check these relations on every cycle:
- the hold phases never overlap, and each keeps its dead gap;
- each hold-pulse width, and the number of cycles by which it outlives its early copy, is measured with counters;
- the early and full-rate phases stay nested inside the active hold window;
- the strobe sits on the final cycle of `ph_two`;
- `ph_two` never rises before `ph_one` after reset.

Only the bench scenarios can show the absolute placement of every edge within the frame, which the bench compares against a position model on every cycle. The same goes for the outputs held at zero through resets applied at random points in the frame, and for `ph_one` rising exactly DEAD+1 cycles after each release.

// File: rtl/npg_pkg.sv
package npg_pkg;

  typedef struct packed {
    logic full;
    logic one;
    logic two;
    logic one_e;
    logic two_e;
    logic stb;
  } npg_phases_t;

  function automatic logic in_span(input int v, input int lo, input int hi);
    return (v >= lo) && (v < hi);
  endfunction

  function automatic logic upper_half(input int pos, input int div);
    return pos >= div;
  endfunction

  function automatic int fold_half(input int pos, input int div);
    return (pos >= div) ? (pos - div) : pos;
  endfunction

  function automatic logic params_ok(input int div, input int dead,
                                     input int early, input int lead);
    return (dead >= 1) && (early >= 1) && (lead >= 0) &&
           (dead + early + lead < div);
  endfunction

endpackage

// File: rtl/npg_frame_counter.sv
module npg_frame_counter #(
  parameter int FRAME = 32,
  localparam int CW = $clog2(FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] pos
);
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else if (pos == LAST) pos <= '0;
    else pos <= pos + 1'b1;
  end
endmodule

// File: rtl/npg_phase_decode.sv
module npg_phase_decode
  import npg_pkg::*;
#(
  parameter int DIV   = 16,
  parameter int DEAD  = 2,
  parameter int EARLY = 2,
  parameter int LEAD  = 1,
  localparam int FRAME = 2 * DIV,
  localparam int CW = $clog2(FRAME)
) (
  input  logic [CW-1:0] pos,
  output npg_phases_t   req
);
  localparam int EARLY_END = DIV - EARLY;
  localparam int FULL_END  = DIV - EARLY - LEAD;

  int  p;
  int  lp;
  logic hi_half;

  always_comb begin
    p       = int'(pos);
    hi_half = upper_half(p, DIV);
    lp      = fold_half(p, DIV);
    req.one   = !hi_half && in_span(lp, DEAD, DIV);
    req.two   =  hi_half && in_span(lp, DEAD, DIV);
    req.one_e = !hi_half && in_span(lp, DEAD, EARLY_END);
    req.two_e =  hi_half && in_span(lp, DEAD, EARLY_END);
    req.full  = in_span(lp, DEAD, FULL_END);
    req.stb   = (p == FRAME - 1);
  end
endmodule

// File: rtl/npg_interlock.sv
module npg_interlock
  import npg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  npg_phases_t req,
  output npg_phases_t ph
);
  // Cross-coupled feedback: a hold phase may only rise once the other is low.
  logic one_gate;
  logic two_gate;

  assign one_gate = ~ph.two;
  assign two_gate = ~ph.one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
    end else begin
      ph.one   <= req.one   & one_gate;
      ph.two   <= req.two   & two_gate;
      ph.one_e <= req.one_e & one_gate;
      ph.two_e <= req.two_e & two_gate;
      ph.full  <= req.full;
      ph.stb   <= req.stb;
    end
  end
endmodule

// File: rtl/nonoverlap_phase_gen.sv
module nonoverlap_phase_gen
  import npg_pkg::*;
#(
  parameter int DIV   = 16,
  parameter int DEAD  = 2,
  parameter int EARLY = 2,
  parameter int LEAD  = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic ph_full,
  output logic ph_one,
  output logic ph_two,
  output logic ph_one_early,
  output logic ph_two_early,
  output logic latch_stb
);
  localparam int FRAME = 2 * DIV;
  localparam int CW = $clog2(FRAME);

  if (!params_ok(DIV, DEAD, EARLY, LEAD)) begin : g_bad_params
    $error("nonoverlap_phase_gen: DEAD/EARLY/LEAD leave a phase pulse without width");
  end

  logic [CW-1:0] frame_pos;
  npg_phases_t   phase_req;
  npg_phases_t   phase_q;

  npg_frame_counter #(.FRAME(FRAME)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .pos  (frame_pos)
  );

  npg_phase_decode #(.DIV(DIV), .DEAD(DEAD), .EARLY(EARLY), .LEAD(LEAD)) u_dec (
    .pos(frame_pos),
    .req(phase_req)
  );

  npg_interlock u_lock (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (phase_req),
    .ph   (phase_q)
  );

  assign ph_full      = phase_q.full;
  assign ph_one       = phase_q.one;
  assign ph_two       = phase_q.two;
  assign ph_one_early = phase_q.one_e;
  assign ph_two_early = phase_q.two_e;
  assign latch_stb    = phase_q.stb;
endmodule

// File: rtl/nonoverlap_phase_gen_chk.sv
module nonoverlap_phase_gen_chk #(
  parameter int DIV   = 16,
  parameter int DEAD  = 2,
  parameter int EARLY = 2,
  parameter int LEAD  = 1
) (
  input logic clk,
  input logic rst_n,
  input logic ph_full,
  input logic ph_one,
  input logic ph_two,
  input logic ph_one_early,
  input logic ph_two_early,
  input logic latch_stb
);
  int   w_one;
  int   w_two;
  int   tail_one;
  int   tail_two;
  logic seen_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_one <= 0; w_two <= 0; tail_one <= 0; tail_two <= 0; seen_one <= 1'b0;
    end else begin
      w_one    <= ph_one ? w_one + 1 : 0;
      w_two    <= ph_two ? w_two + 1 : 0;
      tail_one <= (ph_one && !ph_one_early) ? tail_one + 1 : 0;
      tail_two <= (ph_two && !ph_two_early) ? tail_two + 1 : 0;
      if (ph_one) seen_one <= 1'b1;
    end
  end

  assert_nonoverlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_one && ph_two));
  assert_gap_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_two) |-> !$past(ph_one));
  assert_gap_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_one) |-> !$past(ph_two));
  assert_width_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_one) |-> (w_one == DIV - DEAD));
  assert_width_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_two) |-> (w_two == DIV - DEAD));
  assert_early_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_one) |-> ph_one_early);
  assert_early_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_one_early |-> ph_one) and (ph_two_early |-> ph_two));
  assert_early_lead_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_one) |-> (tail_one == EARLY));
  assert_early_lead_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_two) |-> (tail_two == EARLY));
  assert_full_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ph_full |-> (ph_one_early || ph_two_early));
  assert_stb_in_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> ph_two);
  assert_stb_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> (!latch_stb && !ph_two));
  assert_one_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_two) |-> seen_one);
endmodule

bind nonoverlap_phase_gen nonoverlap_phase_gen_chk #(
  .DIV(DIV), .DEAD(DEAD), .EARLY(EARLY), .LEAD(LEAD)
) u_chk (.*);

// File: tb/nonoverlap_phase_gen_test.sv
module nonoverlap_phase_gen_test;
  localparam int DIV = 10;
  localparam int DEAD = 2;
  localparam int EARLY = 3;
  localparam int LEAD = 1;
  localparam int FRAME = 2 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ph_full, ph_one, ph_two, ph_one_early, ph_two_early, latch_stb;

  int checks = 0;
  int failures = 0;
  int k = 0;
  bit done = 0;
  logic prev_one = 0, prev_two = 0;
  bit first_seen = 0;

  always #10 clk = ~clk;

  nonoverlap_phase_gen #(.DIV(DIV), .DEAD(DEAD), .EARLY(EARLY), .LEAD(LEAD)) uut (
    .clk(clk), .rst_n(rst_n), .ph_full(ph_full), .ph_one(ph_one), .ph_two(ph_two),
    .ph_one_early(ph_one_early), .ph_two_early(ph_two_early), .latch_stb(latch_stb)
  );

  // Expected outputs in the order {full, one, two, one_e, two_e, stb}.
  function automatic logic [5:0] model(input int kk);
    int p, lp;
    bit second;
    logic [5:0] e;
    if (kk <= 0) return 6'b0;
    p = (kk - 1) % FRAME;
    second = (p >= DIV);
    lp = second ? p - DIV : p;
    e[4] = !second && (lp >= DEAD);
    e[3] =  second && (lp >= DEAD);
    e[2] = !second && (lp >= DEAD) && (lp + EARLY < DIV);
    e[1] =  second && (lp >= DEAD) && (lp + EARLY < DIV);
    e[5] = (lp >= DEAD) && (lp + EARLY + LEAD < DIV);
    e[0] = (p == FRAME - 1);
    return e;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s k=%0d actual=%b expected=%b", req, k, act, exp);
    end
  endtask

  task automatic cyc();
    logic [5:0] e;
    @(posedge clk);
    if (rst_n) k++; else k = 0;
    @(negedge clk);
    e = rst_n ? model(k) : 6'b0;
    if (!rst_n) begin
      check("R1 reset", |{ph_full, ph_one, ph_two, ph_one_early, ph_two_early, latch_stb}, 1'b0);
    end else begin
      check("R6 ph_full", ph_full, e[5]);
      check("R2 ph_one", ph_one, e[4]);
      check("R3 ph_two", ph_two, e[3]);
      check("R5 ph_one_early", ph_one_early, e[2]);
      check("R5 ph_two_early", ph_two_early, e[1]);
      check("R7 latch_stb", latch_stb, e[0]);
      check("R4 overlap", ph_one & ph_two, 1'b0);
      if (!first_seen && ((ph_one && !prev_one) || (ph_two && !prev_two))) begin
        first_seen = 1;
        check("R8 first is ph_one", ph_one, 1'b1);
        check("R8 first rise cycle", k == DEAD + 1, 1'b1);
      end
    end
    prev_one = ph_one;
    prev_two = ph_two;
  endtask

  task automatic reset_for(input int n);
    rst_n = 1'b0;
    for (int i = 0; i < n; i++) cyc();
    rst_n = 1'b1;
    first_seen = 0;
    // R1: right after release, before any edge, outputs are still zero.
    check("R1 after release", |{ph_full, ph_one, ph_two, ph_one_early, ph_two_early, latch_stb}, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    @(negedge clk);
    reset_for(4);
    for (int i = 0; i < 3 * FRAME; i++) cyc();
    // Short reset inside the ph_two window (directed corner).
    while (!(ph_two && !latch_stb)) cyc();
    reset_for(1);
    for (int i = 0; i < 2 * FRAME; i++) cyc();
    for (int it = 0; it < 12; it++) begin
      int run_len = $urandom_range(1, 3 * FRAME);
      int rst_len = $urandom_range(1, 4);
      for (int i = 0; i < run_len; i++) cyc();
      reset_for(rst_len);
    end
    for (int i = 0; i < 2 * FRAME; i++) cyc();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule